// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM of 256K words, each 16 bits wide. A client raises `req` with a read/write flag, a word address, write data and a two-bit lane mask. The request is taken on the first clock edge where `ready` is high. The controller then runs the memory's strobes through a fixed sequence of phases and reports completion with a one-cycle `ack`. For a read, `rvalid` and `rdata` arrive in the same cycle as `ack`.

The length of each phase, in clock cycles, is worked out at elaboration from the memory's nanosecond minimums and the `CLK_PERIOD_NS` parameter. Each length is rounded up and is never less than one cycle. The data bus is split into an output, an output-enable and an input, so that the pad cell can sit outside this block. Every write is ended by raising the write strobe, while chip enable, the byte enables and the write data are all still held. After every read, the controller waits a gap before it can drive the bus again, so the memory's output drivers have time to turn off.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `ack` and `rvalid` are 0, `mem_dq_oe` is 0, and `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_be_n` are 1.
- R2: A read with a non-zero mask holds `mem_ce_n`, `mem_oe_n` and the selected byte enables low for exactly ceil(55/CLK_PERIOD_NS) cycles. In the first cycle after they rise, `ack` and `rvalid` are both 1 for that one cycle.
- R3: `rdata` is the value on `mem_dq_i` in the last cycle that the read strobes are active.
- R4: A write drives chip enable, the byte enables and `mem_dq_o` for ceil(max(50-45,0)/CLK_PERIOD_NS) cycles, at least one, before `mem_we_n` falls. `mem_we_n` then stays low for exactly ceil(45/CLK_PERIOD_NS) cycles. It rises while chip enable, the byte enables and the data drive are still held, and with `mem_oe_n` high throughout.
- R5: During a write, chip enable stays low for setup + pulse + recovery cycles. Recovery is max(1, ceil(55/T) - setup - pulse), where T is CLK_PERIOD_NS. `ack` is 1 in the last recovery cycle.
- R6: Mask bit 1 drives `mem_be_n[1]` (upper byte, active low) and mask bit 0 drives `mem_be_n[0]` (lower byte). A write changes only the lanes that are enabled.
- R7: A request whose mask is 0 starts no memory cycle. `ack` is 1 in the cycle after it is accepted, and `ready` stays 1.
- R8: After the `ack` of a read, `ready` stays low for exactly ceil(20/CLK_PERIOD_NS) cycles. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R9: `ready` is 0 from the cycle after a memory cycle is accepted until that cycle is complete. While `ready` is 1, all memory strobes are inactive.
- R10: `mem_addr` holds the request's address and does not change while `mem_ce_n` is low. `mem_dq_o` carries the request's write data when the write strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request; accepted on an edge where `ready` is 1 |
| ready | output | 1 | Controller idle and able to take a request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| mask | input | 2 | Lane mask: bit 1 upper byte, bit 0 lower byte |
| ack | output | 1 | One-cycle completion pulse |
| rvalid | output | 1 | Read data valid (one cycle) |
| rdata | output | 16 | Captured read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low: bit 1 upper, bit 0 lower |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_i | input | 16 | Data read from the memory |

## Verification
The bench measures every strobe's low time in cycles and compares it with counts it computes from the nanosecond minimums. A controller that ends a phase one cycle early would therefore shorten a read access or the write pulse, and that shows up directly. At the edge where the write strobe rises, the bench checks that chip enable, the byte enables, the data drive, the address and the write data are all still in place. A design that ended the write with another strobe, or dropped the data at the same edge, would be caught there. Further tests cover a write to a single lane followed by a read of both lanes, a request with a zero mask (which must leave no strobe activity), and a read followed at once by a write. The last case exposes a missing turnaround gap, or a data drive that starts while the memory is still driving the bus.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int T_RC_NS = 55,
  parameter int T_WC_NS = 55,
  parameter int T_PWE_NS = 45,
  parameter int T_BW_NS = 50,
  parameter int T_HZ_NS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    mask,
  output logic          ack,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [1:0]    mem_be_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  function automatic int cdiv(input int ns);
    int r;
    r = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (r < 1) ? 1 : r;
  endfunction

  localparam int N_RD = cdiv(T_RC_NS);
  localparam int N_WP = cdiv(T_PWE_NS);
  localparam int N_WS = cdiv((T_BW_NS > T_PWE_NS) ? T_BW_NS - T_PWE_NS : 0);
  localparam int N_WC = cdiv(T_WC_NS);
  localparam int N_WR = (N_WC - N_WS - N_WP < 1) ? 1 : N_WC - N_WS - N_WP;
  localparam int N_TA = cdiv(T_HZ_NS);
  localparam int CW = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ACC, S_RD_CAP, S_TURN, S_WR_SET, S_WR_PULSE, S_WR_REC
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rdata_q;
  logic [1:0]      mask_q;
  logic            zack_q;
  logic            cyc_on;
  logic            last;

  assign last      = (cnt == '0);
  assign cyc_on    = (state == S_RD_ACC) || (state == S_WR_SET) ||
                     (state == S_WR_PULSE) || (state == S_WR_REC);
  assign ready     = (state == S_IDLE);
  assign mem_ce_n  = !cyc_on;
  assign mem_oe_n  = (state != S_RD_ACC);
  assign mem_we_n  = (state != S_WR_PULSE);
  assign mem_be_n  = cyc_on ? ~mask_q : 2'b11;
  assign mem_dq_oe = (state == S_WR_SET) || (state == S_WR_PULSE) || (state == S_WR_REC);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rvalid    = (state == S_RD_CAP);
  assign rdata     = rdata_q;
  assign ack       = rvalid || zack_q || ((state == S_WR_REC) && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      mask_q  <= '0;
      zack_q  <= 1'b0;
    end else begin
      zack_q <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          mask_q  <= mask;
          if (mask == 2'b00) begin
            zack_q <= 1'b1;
          end else if (we) begin
            state <= S_WR_SET;
            cnt   <= CW'(N_WS - 1);
          end else begin
            state <= S_RD_ACC;
            cnt   <= CW'(N_RD - 1);
          end
        end
        S_RD_ACC: if (last) begin
          rdata_q <= mem_dq_i;
          state   <= S_RD_CAP;
        end else cnt <= cnt - CW'(1);
        S_RD_CAP: begin
          state <= S_TURN;
          cnt   <= CW'(N_TA - 1);
        end
        S_TURN: if (last) state <= S_IDLE;
                else cnt <= cnt - CW'(1);
        S_WR_SET: if (last) begin
          state <= S_WR_PULSE;
          cnt   <= CW'(N_WP - 1);
        end else cnt <= cnt - CW'(1);
        S_WR_PULSE: if (last) begin
          state <= S_WR_REC;
          cnt   <= CW'(N_WR - 1);
        end else cnt <= cnt - CW'(1);
        S_WR_REC: if (last) state <= S_IDLE;
                  else cnt <= cnt - CW'(1);
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int AW = 18,
  parameter int T_RC_NS = 55,
  parameter int T_PWE_NS = 45,
  parameter int T_HZ_NS = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          ack,
  input logic          rvalid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [1:0]    mem_be_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe
);
  localparam int C_RD = (T_RC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_WP = (T_PWE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_TA = (T_HZ_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  int we_run, oe_run, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run   <= 0;
      oe_run   <= 0;
      since_oe <= 1000;
    end else begin
      we_run   <= mem_we_n ? 0 : we_run + 1;
      oe_run   <= mem_oe_n ? 0 : oe_run + 1;
      since_oe <= !mem_oe_n ? 0 : (since_oe < 1000 ? since_oe + 1 : since_oe);
    end
  end

  assert_we_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_be_n != 2'b11 && mem_oe_n && mem_dq_oe));
  assert_we_ends_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_be_n != 2'b11 && mem_dq_oe));
  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= C_WP));
  assert_oe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run >= C_RD));
  assert_rvalid_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ack);
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_oe >= C_TA));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .AW(AW), .T_RC_NS(T_RC_NS),
  .T_PWE_NS(T_PWE_NS), .T_HZ_NS(T_HZ_NS)
) u_asram_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .ack(ack), .rvalid(rvalid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int T = 10;
  localparam int E_RD = (55 + T - 1) / T;
  localparam int E_WP = (45 + T - 1) / T;
  localparam int E_WS = 1;
  localparam int E_WR = (E_RD - E_WS - E_WP < 1) ? 1 : E_RD - E_WS - E_WP;
  localparam int E_TA = (20 + T - 1) / T;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] mask = '0;
  logic ready, ack, rvalid;
  logic [15:0] rdata;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0] mem_be_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mem [0:63];
  logic [17:0] exp_addr;
  logic [15:0] exp_wdata;
  int strobe_cnt = 0;

  always #10 clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .we(we), .addr(addr),
    .wdata(wdata), .mask(mask), .ack(ack), .rvalid(rvalid), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always_comb begin
    mem_dq_i = 16'h0000;
    if (!mem_ce_n && !mem_oe_n) begin
      if (!mem_be_n[1]) mem_dq_i[15:8] = mem[mem_addr[5:0]][15:8];
      if (!mem_be_n[0]) mem_dq_i[7:0]  = mem[mem_addr[5:0]][7:0];
    end
  end

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  int oe_run = 0, we_run = 0, ce_run = 0, since_oe = 1000;
  bit p_oe = 1, p_we = 1, p_ce = 1, wr_seen = 0, p_dqoe = 0;
  logic [17:0] p_addr;
  always @(negedge clk) if (rst_n) begin
    if (!mem_ce_n) strobe_cnt++;
    if (!mem_ce_n && !p_ce) check(mem_addr == p_addr, "R10 addr stable", mem_addr, p_addr);
    if (!mem_we_n && p_we) begin
      check(ce_run == E_WS, "R4 setup cycles", ce_run, E_WS);
      check(mem_dq_oe, "R4 data driven before pulse", mem_dq_oe, 1);
      wr_seen = 1;
    end
    if (mem_we_n && !p_we) begin
      check(we_run == E_WP, "R4 pulse width", we_run, E_WP);
      check(!mem_ce_n && mem_dq_oe && mem_be_n != 2'b11, "R4 we ends first",
            {mem_ce_n, mem_dq_oe}, 2'b01);
      check(mem_dq_o == exp_wdata, "R10 write data", mem_dq_o, exp_wdata);
      check(mem_addr == exp_addr, "R10 write addr", mem_addr, exp_addr);
      if (!mem_be_n[1]) mem[mem_addr[5:0]][15:8] = mem_dq_o[15:8];
      if (!mem_be_n[0]) mem[mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
    end
    if (mem_oe_n && !p_oe) begin
      check(oe_run == E_RD, "R2 read strobe length", oe_run, E_RD);
      check(rvalid && ack, "R2 rvalid/ack after strobes", {rvalid, ack}, 2'b11);
    end
    if (mem_ce_n && !p_ce && wr_seen) begin
      check(ce_run == E_WS + E_WP + E_WR, "R5 write ce length", ce_run, E_WS + E_WP + E_WR);
      wr_seen = 0;
    end
    if (mem_dq_oe && !p_dqoe)
      check(since_oe >= E_TA, "R8 turnaround before drive", since_oe, E_TA);
    if (mem_dq_oe) check(mem_oe_n, "R8 no drive during read", mem_oe_n, 1);
    oe_run   = mem_oe_n ? 0 : oe_run + 1;
    we_run   = mem_we_n ? 0 : we_run + 1;
    ce_run   = mem_ce_n ? 0 : ce_run + 1;
    since_oe = !mem_oe_n ? 0 : (since_oe < 1000 ? since_oe + 1 : since_oe);
    p_oe = mem_oe_n; p_we = mem_we_n; p_ce = mem_ce_n; p_dqoe = mem_dq_oe;
    p_addr = mem_addr;
  end

  task automatic do_req(input bit w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd, output bit rv,
                        output bit ack_ready);
    int n;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; mask = m;
    exp_addr = a; exp_wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 0;
    if (m != 2'b00) check(!ready, "R9 ready low while busy", ready, 0);
    n = 0;
    while (!ack && n < 50) begin @(negedge clk); n++; end
    check(ack, "R2 ack arrives", ack, 1);
    rd = rdata; rv = rvalid; ack_ready = ready;
    while (!ready && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    check(ready && !ack && !rvalid && !mem_dq_oe, "R1 reset control",
          {ready, ack, rvalid, mem_dq_oe}, 4'b1000);
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11, "R1 reset strobes",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 5'b11111);
  endtask

  task automatic t_full_word();
    logic [15:0] rd; bit rv, ar;
    do_req(1, 18'd5, 16'hA55A, 2'b11, rd, rv, ar);
    do_req(0, 18'd5, 16'h0, 2'b11, rd, rv, ar);
    check(rv, "R2 rvalid with ack", rv, 1);
    check(rd == 16'hA55A, "R3 read data", rd, 16'hA55A);
  endtask

  task automatic t_byte_lanes();
    logic [15:0] rd; bit rv, ar;
    do_req(1, 18'd5, 16'h1234, 2'b01, rd, rv, ar);
    do_req(0, 18'd5, 16'h0, 2'b11, rd, rv, ar);
    check(rd == 16'hA534, "R6 lower lane write", rd, 16'hA534);
    do_req(1, 18'd5, 16'h7799, 2'b10, rd, rv, ar);
    do_req(0, 18'd5, 16'h0, 2'b11, rd, rv, ar);
    check(rd == 16'h7734, "R6 upper lane write", rd, 16'h7734);
    do_req(0, 18'd5, 16'h0, 2'b01, rd, rv, ar);
    check(rd == 16'h0034, "R6 lower lane read", rd, 16'h0034);
  endtask

  task automatic t_zero_mask();
    logic [15:0] rd; bit rv, ar; int s0;
    s0 = strobe_cnt;
    do_req(1, 18'd5, 16'hFFFF, 2'b00, rd, rv, ar);
    check(ar, "R7 ready stays high", ar, 1);
    check(strobe_cnt == s0, "R7 no memory cycle", strobe_cnt - s0, 0);
    do_req(0, 18'd5, 16'h0, 2'b11, rd, rv, ar);
    check(rd == 16'h7734, "R7 memory untouched", rd, 16'h7734);
  endtask

  task automatic t_top_addr_turn();
    logic [15:0] rd; bit rv, ar; int n;
    do_req(1, 18'h3FFFF, 16'hC3E1, 2'b11, rd, rv, ar);
    @(negedge clk);
    req = 1; we = 0; addr = 18'h3FFFF; mask = 2'b11;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1; we = 1; addr = 18'd9; wdata = 16'h0F0F; mask = 2'b11;
    while (!ack) @(negedge clk);
    check(rdata == 16'hC3E1, "R3 top address read", rdata, 16'hC3E1);
    exp_addr = 18'd9; exp_wdata = 16'h0F0F;
    n = 0;
    @(negedge clk);
    while (!ready && n < 20) begin n++; @(negedge clk); end
    check(n == E_TA, "R8 turnaround length", n, E_TA);
    @(negedge clk);
    req = 0;
    while (!ack) @(negedge clk);
    while (!ready) @(negedge clk);
    check(mem[9] == 16'h0F0F, "R5 back-to-back write", mem[9], 16'h0F0F);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_full_word();
    t_byte_lanes();
    t_zero_mask();
    t_top_addr_turn();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule